// File: doc/BRIEF.md
# Garbage-Collection Interrupt Enable Unit

This unit keeps a single user-visible enable bit that decides whether a garbage-collection timer may interrupt the processor. It sits in the control-status logic. Each cycle it looks at the retiring instructions and the current privilege level. A subroutine call or a stack-reserving adjust that retires at user level clears the bit by hardware. This keeps the collector out of a function until its prologue has finished. Software then sets the bit again with a CSR write once the frame is complete.

A write that tries to set the bit takes effect only at user level. Library routines that run at any privilege can therefore write the set value without turning the collector on inside supervisor or machine code. A write of zero clears the bit at any level. The request from the dedicated collection timer is combined with the bit to form a registered interrupt request.

Top module: `gc_irq_enable`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the enable bit is 0, `gc_irq` is 0 and `csr_rdata` is 0.
- R2: A retire on a valid lane with class code 1 (direct call) or 2 (indirect call) while `priv_lvl` is 2'b00 (user) clears the enable bit at that clock edge.
- R3: A retire with class code 3 (stack-reserving adjust) while `priv_lvl` is 2'b00 clears the enable bit when `STACK_ADJ_CLEARS` is 1, which is the default.
- R4: Retires of any class while `priv_lvl` is not 2'b00 leave the enable bit unchanged. Class code 0 never changes it, at any privilege level.
- R5: A CSR write with `csr_addr` equal to `GC_CSR_ADDR`, `csr_wdata[0]`=1 and `priv_lvl`=2'b00 sets the enable bit at that clock edge.
- R6: A CSR write of `csr_wdata[0]`=1 while `priv_lvl` is not 2'b00 has no effect on the enable bit.
- R7: A CSR write of `csr_wdata[0]`=0 to `GC_CSR_ADDR` clears the enable bit at every privilege level.
- R8: When an automatic clear (R2/R3) and a setting CSR write fall in the same cycle, the enable bit ends at 0.
- R9: A read with `csr_re`=1 and `csr_addr`=`GC_CSR_ADDR` returns, one cycle later on `csr_rdata`, the enable value from before that edge in bit 0, with all other bits 0. Reads of other addresses return 0. Writes to other addresses leave the bit unchanged.
- R10: `gc_irq` is 1 in the cycle after an edge exactly when `gc_timer_req` was 1 and the enable bit was 1 before that edge.
- R11: With several retire lanes, one qualifying valid lane is enough to clear the bit. A lane with its valid bit low is ignored, whatever its class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | RETIRE_W | Per-lane retire strobe |
| ret_class | input | 2*RETIRE_W | Per-lane instruction class, lane i at bits [2i+1:2i] |
| priv_lvl | input | 2 | Current privilege level, 2'b00 is user |
| csr_we | input | 1 | CSR write strobe |
| csr_re | input | 1 | CSR read strobe |
| csr_addr | input | CSR_AW | CSR address for read or write |
| csr_wdata | input | XLEN | CSR write data, bit 0 is the enable |
| csr_rdata | output | XLEN | Registered CSR read data |
| gc_timer_req | input | 1 | Request from the collection timer |
| gc_irq | output | 1 | Gated, registered collection interrupt request |

## Verification
The main function is driven with random mixes of privilege levels, lane valids and class codes, both against a steady timer request and a toggling one. This separates a clear caused by privilege gating from a clear caused by class decoding. Directed sequences set the bit at user level and then attempt calls and setting writes at machine level, which tells a privilege check that is missing from one applied to the wrong operation. Collisions of a call and a setting write in the same cycle check the clear priority. Read-after-write in the same cycle checks that reads return the value from before the edge. A call on a high lane with lane 0 idle, and invalid lanes carrying call codes, show that every lane is decoded and that valid gates it.

// File: rtl/gc_irq_enable_pkg.sv
package gc_irq_enable_pkg;

  localparam int unsigned GC_CLS_W  = 2;
  localparam int unsigned GC_PRIV_W = 2;

  typedef enum logic [GC_CLS_W-1:0] {
    CLS_OTHER     = 2'd0,
    CLS_CALL_DIR  = 2'd1,
    CLS_CALL_IND  = 2'd2,
    CLS_STACK_ADJ = 2'd3
  } gc_cls_e;

  typedef enum logic [GC_PRIV_W-1:0] {
    PRV_USER  = 2'b00,
    PRV_SUPER = 2'b01,
    PRV_RSVD  = 2'b10,
    PRV_MACH  = 2'b11
  } gc_priv_e;

endpackage

// File: rtl/gc_retire_decode.sv
module gc_retire_decode
  import gc_irq_enable_pkg::*;
#(
  parameter int unsigned RETIRE_W         = 2,
  parameter bit          STACK_ADJ_CLEARS = 1'b1
) (
  input  logic [RETIRE_W-1:0]          ret_valid,
  input  logic [GC_CLS_W*RETIRE_W-1:0] ret_class,
  input  logic                         at_user,
  output logic                         auto_clr
);

  logic [RETIRE_W-1:0] lane_hit;

  for (genvar g = 0; g < RETIRE_W; g++) begin : g_lane
    gc_cls_e cls;
    logic    is_call;
    logic    is_adj;
    assign cls     = gc_cls_e'(ret_class[g*GC_CLS_W +: GC_CLS_W]);
    assign is_call = (cls == CLS_CALL_DIR) || (cls == CLS_CALL_IND);
    if (STACK_ADJ_CLEARS) begin : g_adj_on
      assign is_adj = (cls == CLS_STACK_ADJ);
    end else begin : g_adj_off
      assign is_adj = 1'b0;
    end
    assign lane_hit[g] = ret_valid[g] && (is_call || is_adj);
  end

  assign auto_clr = at_user && (|lane_hit);

endmodule

// File: rtl/gc_csr_port.sv
module gc_csr_port #(
  parameter int unsigned         XLEN        = 32,
  parameter int unsigned         CSR_AW      = 12,
  parameter logic [CSR_AW-1:0]   GC_CSR_ADDR = 12'h8C0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic              csr_re,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic              en_cur,
  output logic              wr_hit,
  output logic              wr_bit,
  output logic [XLEN-1:0]   csr_rdata
);

  logic addr_hit;

  assign addr_hit = (csr_addr == GC_CSR_ADDR);
  assign wr_hit   = csr_we && addr_hit;
  assign wr_bit   = csr_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata <= '0;
    end else if (csr_re && addr_hit) begin
      csr_rdata <= {{(XLEN-1){1'b0}}, en_cur};
    end else begin
      csr_rdata <= '0;
    end
  end

endmodule

// File: rtl/gc_enable_reg.sv
module gc_enable_reg (
  input  logic clk,
  input  logic rst,
  input  logic at_user,
  input  logic auto_clr,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic en_q
);

  logic en_d;

  always_comb begin
    en_d = en_q;
    if (wr_hit) begin
      if (!wr_bit) begin
        en_d = 1'b0;
      end else if (at_user) begin
        en_d = 1'b1;
      end
    end
    if (auto_clr) begin
      en_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

endmodule

// File: rtl/gc_irq_enable.sv
module gc_irq_enable
  import gc_irq_enable_pkg::*;
#(
  parameter int unsigned       RETIRE_W         = 2,
  parameter int unsigned       XLEN             = 32,
  parameter int unsigned       CSR_AW           = 12,
  parameter logic [CSR_AW-1:0] GC_CSR_ADDR      = 12'h8C0,
  parameter bit                STACK_ADJ_CLEARS = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [RETIRE_W-1:0]          ret_valid,
  input  logic [GC_CLS_W*RETIRE_W-1:0] ret_class,
  input  logic [GC_PRIV_W-1:0]         priv_lvl,
  input  logic                         csr_we,
  input  logic                         csr_re,
  input  logic [CSR_AW-1:0]            csr_addr,
  input  logic [XLEN-1:0]              csr_wdata,
  output logic [XLEN-1:0]              csr_rdata,
  input  logic                         gc_timer_req,
  output logic                         gc_irq
);

  logic at_user;
  logic auto_clr;
  logic wr_hit;
  logic wr_bit;
  logic en_q;

  assign at_user = (gc_priv_e'(priv_lvl) == PRV_USER);

  gc_retire_decode #(
    .RETIRE_W        (RETIRE_W),
    .STACK_ADJ_CLEARS(STACK_ADJ_CLEARS)
  ) i_decode (
    .ret_valid(ret_valid),
    .ret_class(ret_class),
    .at_user  (at_user),
    .auto_clr (auto_clr)
  );

  gc_csr_port #(
    .XLEN       (XLEN),
    .CSR_AW     (CSR_AW),
    .GC_CSR_ADDR(GC_CSR_ADDR)
  ) i_csr (
    .clk      (clk),
    .rst      (rst),
    .csr_we   (csr_we),
    .csr_re   (csr_re),
    .csr_addr (csr_addr),
    .csr_wdata(csr_wdata),
    .en_cur   (en_q),
    .wr_hit   (wr_hit),
    .wr_bit   (wr_bit),
    .csr_rdata(csr_rdata)
  );

  gc_enable_reg i_en (
    .clk     (clk),
    .rst     (rst),
    .at_user (at_user),
    .auto_clr(auto_clr),
    .wr_hit  (wr_hit),
    .wr_bit  (wr_bit),
    .en_q    (en_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gc_irq <= 1'b0;
    end else begin
      gc_irq <= gc_timer_req && en_q;
    end
  end

endmodule

// File: rtl/gc_irq_enable_chk.sv
module gc_irq_enable_chk #(
  parameter int unsigned       RETIRE_W    = 2,
  parameter int unsigned       XLEN        = 32,
  parameter int unsigned       CSR_AW      = 12,
  parameter logic [CSR_AW-1:0] GC_CSR_ADDR = 12'h8C0
) (
  input logic                  clk,
  input logic                  rst,
  input logic [RETIRE_W-1:0]   ret_valid,
  input logic [2*RETIRE_W-1:0] ret_class,
  input logic [1:0]            priv_lvl,
  input logic                  csr_we,
  input logic [CSR_AW-1:0]     csr_addr,
  input logic [XLEN-1:0]       csr_wdata,
  input logic [XLEN-1:0]       csr_rdata,
  input logic                  gc_timer_req,
  input logic                  gc_irq,
  input logic                  en_q
);

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
    gc_irq |-> ($past(gc_timer_req) && $past(en_q)));

  p_set_only_user_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> $past(csr_we && (csr_addr == GC_CSR_ADDR) && csr_wdata[0] && (priv_lvl == 2'b00)));

  p_call_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (ret_valid[0] && (ret_class[1:0] == 2'd1 || ret_class[1:0] == 2'd2) && priv_lvl == 2'b00) |=> !en_q);

  p_priv_call_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (priv_lvl != 2'b00 && !csr_we) |=> $stable(en_q));

  p_rdata_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
    csr_rdata[XLEN-1:1] == '0);

endmodule

bind gc_irq_enable gc_irq_enable_chk #(
  .RETIRE_W   (RETIRE_W),
  .XLEN       (XLEN),
  .CSR_AW     (CSR_AW),
  .GC_CSR_ADDR(GC_CSR_ADDR)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .ret_valid   (ret_valid),
  .ret_class   (ret_class),
  .priv_lvl    (priv_lvl),
  .csr_we      (csr_we),
  .csr_addr    (csr_addr),
  .csr_wdata   (csr_wdata),
  .csr_rdata   (csr_rdata),
  .gc_timer_req(gc_timer_req),
  .gc_irq      (gc_irq),
  .en_q        (en_q)
);

// File: tb/test_gc_irq_enable.sv
module test_gc_irq_enable;

  localparam int unsigned LANES = 2;
  localparam int unsigned XL    = 32;
  localparam int unsigned AW    = 12;
  localparam logic [AW-1:0] GADDR = 12'h8C0;

  logic              clk = 1'b0;
  logic              rst;
  logic [LANES-1:0]  ret_valid;
  logic [2*LANES-1:0] ret_class;
  logic [1:0]        priv_lvl;
  logic              csr_we, csr_re;
  logic [AW-1:0]     csr_addr;
  logic [XL-1:0]     csr_wdata;
  logic [XL-1:0]     csr_rdata;
  logic              gc_timer_req;
  logic              gc_irq;

  int n_vec = 0;
  int n_bad = 0;
  logic m_en = 1'b0;
  logic m_irq = 1'b0;
  logic [XL-1:0] m_rd = '0;

  always #2 clk = ~clk;

  gc_irq_enable i_gc_irq_enable (
    .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_class(ret_class),
    .priv_lvl(priv_lvl), .csr_we(csr_we), .csr_re(csr_re), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .gc_timer_req(gc_timer_req),
    .gc_irq(gc_irq)
  );

  function automatic logic next_en(logic cur, logic [LANES-1:0] v, logic [2*LANES-1:0] c,
                                   logic [1:0] p, logic we, logic [AW-1:0] a, logic [XL-1:0] d);
    logic nx = cur;
    logic clr = 1'b0;
    if (we && a == GADDR) begin
      if (!d[0]) nx = 1'b0;
      else if (p == 2'b00) nx = 1'b1;
    end
    for (int k = 0; k < LANES; k++)
      if (v[k] && c[2*k +: 2] != 2'd0 && p == 2'b00) clr = 1'b1;
    if (clr) nx = 1'b0;
    return nx;
  endfunction

  task automatic check(string tag);
    n_vec++;
    if (gc_irq !== m_irq) begin
      n_bad++;
      $display("FAIL %s gc_irq act=%0b exp=%0b", tag, gc_irq, m_irq);
    end
    n_vec++;
    if (csr_rdata !== m_rd) begin
      n_bad++;
      $display("FAIL %s csr_rdata act=%h exp=%h", tag, csr_rdata, m_rd);
    end
  endtask

  task automatic idle_in();
    ret_valid = '0; ret_class = '0; priv_lvl = 2'b00; csr_we = 0; csr_re = 0;
    csr_addr = GADDR; csr_wdata = '0; gc_timer_req = 0;
  endtask

  // drive at negedge, update model at posedge, check 1 ns later
  task automatic step(string tag);
    logic old;
    @(posedge clk);
    old   = m_en;
    m_irq = gc_timer_req && old;
    m_rd  = (csr_re && csr_addr == GADDR) ? {{(XL-1){1'b0}}, old} : '0;
    m_en  = next_en(old, ret_valid, ret_class, priv_lvl, csr_we, csr_addr, csr_wdata);
    #1;
    check(tag);
    @(negedge clk);
    idle_in();
  endtask

  // probe: read with timer on, then observe one cycle later
  task automatic probe(string tag);
    csr_re = 1; gc_timer_req = 1;
    step(tag);
    step(tag);
  endtask

  task automatic wr(logic [1:0] p, logic b, string tag);
    priv_lvl = p; csr_we = 1; csr_wdata = {{(XL-1){1'b0}}, b};
    step(tag);
  endtask

  task automatic ret1(int lane, logic [1:0] cls, logic v, logic [1:0] p, string tag);
    priv_lvl = p; ret_valid[lane] = v; ret_class[2*lane +: 2] = cls;
    step(tag);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h6C5EED01));
    idle_in();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    csr_re = 1; gc_timer_req = 1;
    #1; n_vec++;
    if (gc_irq !== 0 || csr_rdata !== '0) begin
      n_bad++; $display("FAIL R1 in reset act=%0b/%h exp=0/0", gc_irq, csr_rdata);
    end
    rst = 0;
    step("R1"); step("R1");

    wr(2'b00, 1, "R5"); probe("R5");
    ret1(0, 2'd1, 1, 2'b00, "R2"); probe("R2");
    wr(2'b00, 1, "R5"); ret1(1, 2'd2, 1, 2'b00, "R11"); probe("R11");
    wr(2'b00, 1, "R5"); ret1(0, 2'd3, 1, 2'b00, "R3"); probe("R3");
    wr(2'b00, 1, "R5");
    ret1(0, 2'd1, 1, 2'b11, "R4"); ret1(1, 2'd3, 1, 2'b01, "R4");
    ret1(0, 2'd0, 1, 2'b00, "R4"); probe("R4");
    ret1(1, 2'd2, 0, 2'b00, "R11"); probe("R11");
    wr(2'b11, 0, "R7"); probe("R7");
    wr(2'b11, 1, "R6"); wr(2'b01, 1, "R6"); probe("R6");
    wr(2'b00, 1, "R5");
    priv_lvl = 2'b00; csr_we = 1; csr_addr = 12'h8C1; csr_wdata = 0; step("R9");
    probe("R9");
    csr_re = 1; csr_addr = 12'h001; step("R9"); step("R9");
    csr_we = 1; csr_re = 1; csr_wdata = 0; step("R9"); step("R9");
    wr(2'b00, 1, "R5");
    priv_lvl = 2'b00; csr_we = 1; csr_wdata = 1; ret_valid[1] = 1; ret_class[3:2] = 2'd1;
    step("R8"); probe("R8");
    wr(2'b00, 1, "R10"); gc_timer_req = 1; step("R10"); step("R10");

    for (int i = 0; i < 3000; i++) begin
      ret_valid    = LANES'($urandom);
      ret_class    = (2*LANES)'($urandom);
      priv_lvl     = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
      csr_we       = ($urandom % 4 == 0);
      csr_re       = ($urandom % 2 == 0);
      csr_addr     = ($urandom % 8 == 0) ? AW'($urandom) : GADDR;
      csr_wdata    = ($urandom % 3 == 0) ? XL'($urandom) : XL'($urandom) | 32'd1;
      gc_timer_req = ($urandom % 2 == 0);
      if ($urandom % 4 != 0) ret_valid = ret_valid & ~LANES'($urandom);
      step("R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule